// File: doc/BRIEF.md
# Fixed-Coefficient Colour Space Converter

This block converts 8-bit pixels between the red/green/blue domain and the luma/chroma domain in either direction, using built-in matrix coefficients. A range flag chooses between two coefficient and limit sets. One set is for data that spans the full 8-bit code space. The other is for studio-level video, where luma and primaries stay within 16..235 and chroma stays within ±112 of zero. Results are rounded to nearest and clamped, so they never wrap. Chroma codes can be offset binary or two's complement. The red/green/blue side can carry cyan/magenta/yellow codes instead, by complementing them at the boundary.

A bypass flag skips the matrix. The data still passes through the same decode, clamp and encode steps, and takes the same number of cycles. Every control bit is captured together with the sample it belongs to. Controls can therefore change on any cycle, and each output still reflects the settings that were present when its inputs were taken.

Top module: `csc_conv_top`

## Requirements
- R1: While `rst_n` is low, all three output codes are 0x00.
- R2: Forward direction (`inv_dir`=0, inputs R,G,B on `src0..2`): with the weighted sum S = 306R + 601G + 117B, the luma Y = floor((S + 512) / 1024) appears on `dst0`.
- R3: Forward direction: the blue difference Cb = floor(((1024B − S)·Kb + 2^19) / 2^20) appears on `dst1`, and the red difference Cr = floor(((1024R − S)·Kr + 2^19) / 2^20) appears on `dst2`. Kb,Kr are 578,730 for full range and 591,746 for studio range. A gray input gives zero chroma.
- R4: Inverse direction (`inv_dir`=1, inputs Y,Cb,Cr on `src0..2`): R = rnd(1024Y + Arc·Cr), G = rnd(1024Y − Agc·Cr − Agb·Cb) and B = rnd(1024Y + Abb·Cb) appear on `dst0..2`, where rnd(x) = floor((x + 512) / 1024). (Arc,Agc,Agb,Abb) is (1436,731,352,1815) for full range and (1403,715,344,1772) for studio range.
- R5: The limits are 16..235 for primaries and luma and −112..112 for chroma when `studio_range`=1, and 0..255 and −128..127 otherwise. Each decoded input is clamped to its limit before use, and each result is clamped to its limit before encoding.
- R6: When `chroma_twos`=0, chroma codes are offset binary (code = value + 128). When it is 1, they are two's complement. This applies to chroma inputs and chroma outputs alike. Luma and primary codes are always unsigned.
- R7: When `cmy_side`=1, every red/green/blue-side code is complemented (external = 255 − internal). This applies to the inputs in the forward direction and to the outputs in the inverse direction.
- R8: When `bypass_mtx`=1, channel i of the output is channel i of the input, taken through decode and clamp. A value that moves from the primary side to chroma has 128 subtracted, and a value that moves the other way has 128 added. The value is then clamped and encoded under R5–R7.
- R9: Each output reflects the inputs and control bits sampled exactly 8 rising clock edges earlier, in every mode and in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| inv_dir | input | 1 | 0: primaries to luma/chroma, 1: luma/chroma to primaries |
| studio_range | input | 1 | 1: studio coefficients and limits, 0: full range |
| chroma_twos | input | 1 | Chroma code format, 1 = two's complement |
| cmy_side | input | 1 | Complement the red/green/blue-side codes |
| bypass_mtx | input | 1 | Skip the matrix, keep the latency |
| src0 | input | 8 | R (forward) or Y (inverse) |
| src1 | input | 8 | G (forward) or Cb (inverse) |
| src2 | input | 8 | B (forward) or Cr (inverse) |
| dst0 | output | 8 | Y (forward) or R (inverse) |
| dst1 | output | 8 | Cb (forward) or G (inverse) |
| dst2 | output | 8 | Cr (forward) or B (inverse) |

## Verification
The hardest case to reach from the ports is a control change on every cycle while data is still in flight. If any stage takes its control from the wrong sample, the result looks plausible but is wrong. The bench streams a run of samples in which direction, range, chroma format, complement and bypass all change from one cycle to the next. It checks every output at its exact cycle against a model fed with that sample's own settings. Directed vectors drive the clamps to their limits through inputs below 16, chroma beyond ±112 and saturating inverse sums.

// File: rtl/csc_pkg.sv
package csc_pkg;
  localparam int PIX_W  = 8;
  localparam int IVAL_W = 11;
  localparam int ACC_W  = 36;
  localparam int FRAC   = 10;
  localparam int MID    = 1 << (PIX_W - 1);
  localparam int RSH    = 2 * FRAC;

  // forward luma weights (Q10)
  localparam int KY_R = 306;
  localparam int KY_G = 601;
  localparam int KY_B = 117;

  typedef logic signed [IVAL_W-1:0] ival_t;
  typedef logic signed [ACC_W-1:0]  acc_t;

  typedef struct packed {
    logic inv;
    logic studio;
    logic twos;
    logic cmy;
    logic byp;
  } ctl_t;

  function automatic acc_t k_fwd_cb(input logic studio);
    return studio ? acc_t'(591) : acc_t'(578);
  endfunction

  function automatic acc_t k_fwd_cr(input logic studio);
    return studio ? acc_t'(746) : acc_t'(730);
  endfunction

  function automatic acc_t k_inv_rcr(input logic studio);
    return studio ? acc_t'(1403) : acc_t'(1436);
  endfunction

  function automatic acc_t k_inv_gcr(input logic studio);
    return studio ? acc_t'(715) : acc_t'(731);
  endfunction

  function automatic acc_t k_inv_gcb(input logic studio);
    return studio ? acc_t'(344) : acc_t'(352);
  endfunction

  function automatic acc_t k_inv_bcb(input logic studio);
    return studio ? acc_t'(1772) : acc_t'(1815);
  endfunction

  function automatic ival_t lo_bound(input logic chroma, input logic studio);
    if (chroma) return studio ? ival_t'(-112) : ival_t'(-128);
    return studio ? ival_t'(16) : ival_t'(0);
  endfunction

  function automatic ival_t hi_bound(input logic chroma, input logic studio);
    if (chroma) return studio ? ival_t'(112) : ival_t'(127);
    return studio ? ival_t'(235) : ival_t'(255);
  endfunction

  function automatic ival_t clip(input ival_t v, input ival_t lo, input ival_t hi);
    if (v < lo) return lo;
    if (v > hi) return hi;
    return v;
  endfunction

  // external code -> clamped internal value
  function automatic ival_t decode_code(input logic [PIX_W-1:0] code, input logic chroma,
                                        input logic twos, input logic cmy, input logic studio);
    ival_t v;
    logic [PIX_W-1:0] c;
    c = cmy ? ~code : code;
    if (chroma && twos) v = ival_t'($signed(code));
    else if (chroma)    v = ival_t'({{(IVAL_W-PIX_W){1'b0}}, code}) - ival_t'(MID);
    else                v = ival_t'({{(IVAL_W-PIX_W){1'b0}}, c});
    return clip(v, lo_bound(chroma, studio), hi_bound(chroma, studio));
  endfunction

  // internal value -> clamped external code
  function automatic logic [PIX_W-1:0] encode_val(input ival_t v, input logic chroma,
                                                  input logic twos, input logic cmy, input logic studio);
    ival_t c;
    ival_t o;
    c = clip(v, lo_bound(chroma, studio), hi_bound(chroma, studio));
    if (chroma) o = twos ? c : c + ival_t'(MID);
    else        o = cmy ? ~c : c;
    return o[PIX_W-1:0];
  endfunction

  // round-to-nearest of a Q20 accumulator
  function automatic ival_t round_q(input acc_t a);
    acc_t s;
    s = (a + (acc_t'(1) <<< (RSH - 1))) >>> RSH;
    return ival_t'(s);
  endfunction
endpackage

// File: rtl/csc_ingress.sv
module csc_ingress
  import csc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  ctl_t             ctl_i,
  input  logic [PIX_W-1:0] code_i [3],
  output ctl_t             ctl_o,
  output ival_t            val_o  [3]
);
  logic [PIX_W-1:0] raw_q [3];
  ctl_t             raw_ctl_q;

  // stage 1: capture codes with their own controls
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_ctl_q <= '0;
      for (int ch = 0; ch < 3; ch++) raw_q[ch] <= '0;
    end else begin
      raw_ctl_q <= ctl_i;
      for (int ch = 0; ch < 3; ch++) raw_q[ch] <= code_i[ch];
    end
  end

  // stage 2: decode, complement, clamp
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_o <= '0;
    else        ctl_o <= raw_ctl_q;
  end

  for (genvar ch = 0; ch < 3; ch++) begin : g_dec
    wire is_chroma = raw_ctl_q.inv && (ch != 0);
    wire use_cmy   = raw_ctl_q.cmy && !raw_ctl_q.inv;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) val_o[ch] <= '0;
      else val_o[ch] <= decode_code(raw_q[ch], is_chroma, raw_ctl_q.twos, use_cmy, raw_ctl_q.studio);
    end
  end
endmodule

// File: rtl/csc_matrix.sv
module csc_matrix
  import csc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  ctl_t  ctl_i,
  input  ival_t val_i [3],
  output ctl_t  ctl_o,
  output ival_t res_o [3]
);
  acc_t t_nxt [3];
  acc_t t_q   [3];
  acc_t q_nxt [3];
  acc_t q_q   [3];
  ctl_t c3_q, c4_q;

  // stage 3: luma sum and differences, or full inverse sums, or bypass
  always_comb begin
    acc_t base [3];
    acc_t ysum;
    for (int ch = 0; ch < 3; ch++) base[ch] = acc_t'(val_i[ch]) <<< FRAC;
    ysum = acc_t'(val_i[0]) * acc_t'(KY_R) + acc_t'(val_i[1]) * acc_t'(KY_G)
         + acc_t'(val_i[2]) * acc_t'(KY_B);
    if (ctl_i.byp) begin
      t_nxt[0] = base[0];
      for (int ch = 1; ch < 3; ch++)
        t_nxt[ch] = (acc_t'(val_i[ch]) + (ctl_i.inv ? acc_t'(MID) : -acc_t'(MID))) <<< FRAC;
    end else if (!ctl_i.inv) begin
      t_nxt[0] = ysum;
      t_nxt[1] = base[2] - ysum;
      t_nxt[2] = base[0] - ysum;
    end else begin
      t_nxt[0] = base[0] + acc_t'(val_i[2]) * k_inv_rcr(ctl_i.studio);
      t_nxt[1] = base[0] - acc_t'(val_i[2]) * k_inv_gcr(ctl_i.studio)
                         - acc_t'(val_i[1]) * k_inv_gcb(ctl_i.studio);
      t_nxt[2] = base[0] + acc_t'(val_i[1]) * k_inv_bcb(ctl_i.studio);
    end
  end

  // stage 4: chroma gains (forward), else align to Q20
  always_comb begin
    for (int ch = 0; ch < 3; ch++) q_nxt[ch] = t_q[ch] <<< FRAC;
    if (!c3_q.byp && !c3_q.inv) begin
      q_nxt[1] = t_q[1] * k_fwd_cb(c3_q.studio);
      q_nxt[2] = t_q[2] * k_fwd_cr(c3_q.studio);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c3_q  <= '0;
      c4_q  <= '0;
      ctl_o <= '0;
      for (int ch = 0; ch < 3; ch++) begin
        t_q[ch]   <= '0;
        q_q[ch]   <= '0;
        res_o[ch] <= '0;
      end
    end else begin
      c3_q  <= ctl_i;
      c4_q  <= c3_q;
      ctl_o <= c4_q;
      for (int ch = 0; ch < 3; ch++) begin
        t_q[ch]   <= t_nxt[ch];
        q_q[ch]   <= q_nxt[ch];
        res_o[ch] <= round_q(q_q[ch]);   // stage 5
      end
    end
  end
endmodule

// File: rtl/csc_egress.sv
module csc_egress
  import csc_pkg::*;
#(
  parameter int LATENCY = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ctl_t             ctl_i,
  input  ival_t            res_i  [3],
  output ctl_t             ctl_o,
  output logic [PIX_W-1:0] code_o [3]
);
  localparam int CORE_STAGES = 6;
  localparam int TAIL = LATENCY - CORE_STAGES;

  logic [PIX_W-1:0] enc_q [3];
  ctl_t             enc_ctl_q;

  // stage 6: clamp and encode
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) enc_ctl_q <= '0;
    else        enc_ctl_q <= ctl_i;
  end

  for (genvar ch = 0; ch < 3; ch++) begin : g_enc
    wire is_chroma = !ctl_i.inv && (ch != 0);
    wire use_cmy   = ctl_i.cmy && ctl_i.inv;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) enc_q[ch] <= '0;
      else enc_q[ch] <= encode_val(res_i[ch], is_chroma, ctl_i.twos, use_cmy, ctl_i.studio);
    end
  end

  if (TAIL == 0) begin : g_notail
    assign ctl_o = enc_ctl_q;
    for (genvar ch = 0; ch < 3; ch++) begin : g_pass
      assign code_o[ch] = enc_q[ch];
    end
  end else begin : g_tail
    logic [PIX_W-1:0] dly_q [TAIL][3];
    ctl_t             dly_c [TAIL];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int k = 0; k < TAIL; k++) begin
          dly_c[k] <= '0;
          for (int ch = 0; ch < 3; ch++) dly_q[k][ch] <= '0;
        end
      end else begin
        dly_c[0] <= enc_ctl_q;
        for (int ch = 0; ch < 3; ch++) dly_q[0][ch] <= enc_q[ch];
        for (int k = 1; k < TAIL; k++) begin
          dly_c[k] <= dly_c[k-1];
          for (int ch = 0; ch < 3; ch++) dly_q[k][ch] <= dly_q[k-1][ch];
        end
      end
    end
    assign ctl_o = dly_c[TAIL-1];
    for (genvar ch = 0; ch < 3; ch++) begin : g_out
      assign code_o[ch] = dly_q[TAIL-1][ch];
    end
  end
endmodule

// File: rtl/csc_conv_top.sv
module csc_conv_top
  import csc_pkg::*;
#(
  parameter int LATENCY = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inv_dir,
  input  logic             studio_range,
  input  logic             chroma_twos,
  input  logic             cmy_side,
  input  logic             bypass_mtx,
  input  logic [PIX_W-1:0] src0,
  input  logic [PIX_W-1:0] src1,
  input  logic [PIX_W-1:0] src2,
  output logic [PIX_W-1:0] dst0,
  output logic [PIX_W-1:0] dst1,
  output logic [PIX_W-1:0] dst2
);
  ctl_t             ctl_in;
  logic [PIX_W-1:0] codes_in  [3];
  ctl_t             dec_ctl_w;
  ival_t            dec_val_w [3];
  ctl_t             mtx_ctl_w;
  ival_t            mtx_res_w [3];
  ctl_t             out_ctl_w;
  logic [PIX_W-1:0] codes_out [3];

  assign ctl_in = '{inv: inv_dir, studio: studio_range, twos: chroma_twos,
                    cmy: cmy_side, byp: bypass_mtx};
  assign codes_in[0] = src0;
  assign codes_in[1] = src1;
  assign codes_in[2] = src2;

  csc_ingress u_ingress (
    .clk(clk), .rst_n(rst_n), .ctl_i(ctl_in), .code_i(codes_in),
    .ctl_o(dec_ctl_w), .val_o(dec_val_w)
  );

  csc_matrix u_matrix (
    .clk(clk), .rst_n(rst_n), .ctl_i(dec_ctl_w), .val_i(dec_val_w),
    .ctl_o(mtx_ctl_w), .res_o(mtx_res_w)
  );

  csc_egress #(.LATENCY(LATENCY)) u_egress (
    .clk(clk), .rst_n(rst_n), .ctl_i(mtx_ctl_w), .res_i(mtx_res_w),
    .ctl_o(out_ctl_w), .code_o(codes_out)
  );

  assign dst0 = codes_out[0];
  assign dst1 = codes_out[1];
  assign dst2 = codes_out[2];
endmodule

// File: rtl/csc_conv_chk.sv
module csc_conv_chk
  import csc_pkg::*;
#(
  parameter int LATENCY = 8
) (
  input logic             clk,
  input logic             rst_n,
  input ctl_t             ctl_in,
  input logic [PIX_W-1:0] src0,
  input logic [PIX_W-1:0] src1,
  input logic [PIX_W-1:0] src2,
  input ctl_t             out_ctl,
  input logic [PIX_W-1:0] dst0,
  input logic [PIX_W-1:0] dst1,
  input logic [PIX_W-1:0] dst2
);
  localparam int CW = $clog2(LATENCY + 1);

  logic [CW-1:0]    seen;
  logic [PIX_W-1:0] h0 [LATENCY];
  logic [PIX_W-1:0] h1 [LATENCY];
  logic [PIX_W-1:0] h2 [LATENCY];
  ctl_t             hc [LATENCY];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen <= '0;
    else if (seen != CW'(LATENCY)) seen <= seen + 1'b1;
  end

  always_ff @(posedge clk) begin
    h0[0] <= src0; h1[0] <= src1; h2[0] <= src2; hc[0] <= ctl_in;
    for (int k = 1; k < LATENCY; k++) begin
      h0[k] <= h0[k-1]; h1[k] <= h1[k-1]; h2[k] <= h2[k-1]; hc[k] <= hc[k-1];
    end
  end

  wire              full_hist = (seen == CW'(LATENCY));
  wire ctl_t        hctl = hc[LATENCY-1];
  wire [PIX_W-1:0]  hin0 = h0[LATENCY-1];
  wire [PIX_W-1:0]  hin1 = h1[LATENCY-1];
  wire [PIX_W-1:0]  hin2 = h2[LATENCY-1];

  a_r1_reset_clear: assert property (@(posedge clk)
    !rst_n |-> (dst0 == '0 && dst1 == '0 && dst2 == '0));

  a_r9_ctl_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    full_hist |-> (out_ctl == hctl));

  a_r8_bypass_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    (full_hist && hctl.byp && !hctl.inv && !hctl.studio && !hctl.cmy && !hctl.twos)
    |-> (dst0 == hin0 && dst1 == hin1 && dst2 == hin2));

  a_r5_studio_rgb_bounds: assert property (@(posedge clk) disable iff (!rst_n)
    (full_hist && hctl.studio && hctl.inv && !hctl.cmy)
    |-> (dst0 >= 8'd16 && dst0 <= 8'd235 && dst1 >= 8'd16 && dst1 <= 8'd235
         && dst2 >= 8'd16 && dst2 <= 8'd235));

  a_r5_studio_chroma_bounds: assert property (@(posedge clk) disable iff (!rst_n)
    (full_hist && hctl.studio && !hctl.inv && !hctl.twos)
    |-> (dst0 >= 8'd16 && dst0 <= 8'd235 && dst1 >= 8'd16 && dst1 <= 8'd240
         && dst2 >= 8'd16 && dst2 <= 8'd240));

  a_r3_gray_neutral: assert property (@(posedge clk) disable iff (!rst_n)
    (full_hist && !hctl.inv && !hctl.byp && !hctl.twos && hin0 == hin1 && hin1 == hin2)
    |-> (dst1 == 8'h80 && dst2 == 8'h80));

  a_r2_gray_luma: assert property (@(posedge clk) disable iff (!rst_n)
    (full_hist && !hctl.inv && !hctl.byp && !hctl.studio && !hctl.cmy
     && hin0 == hin1 && hin1 == hin2) |-> (dst0 == hin0));
endmodule

bind csc_conv_top csc_conv_chk #(.LATENCY(LATENCY)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_in(ctl_in),
  .src0(src0), .src1(src1), .src2(src2),
  .out_ctl(out_ctl_w), .dst0(dst0), .dst1(dst1), .dst2(dst2)
);

// File: tb/csc_conv_top_tb.sv
module csc_conv_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LAT = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic inv_dir = 1'b0, studio_range = 1'b0, chroma_twos = 1'b0, cmy_side = 1'b0, bypass_mtx = 1'b0;
  logic [7:0] src0 = '0, src1 = '0, src2 = '0;
  logic [7:0] dst0, dst1, dst2;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  csc_conv_top #(.LATENCY(LAT)) dut_i (
    .clk(clk), .rst_n(rst_n), .inv_dir(inv_dir), .studio_range(studio_range),
    .chroma_twos(chroma_twos), .cmy_side(cmy_side), .bypass_mtx(bypass_mtx),
    .src0(src0), .src1(src1), .src2(src2), .dst0(dst0), .dst1(dst1), .dst2(dst2)
  );

  // ---------------- reference model from the requirements ----------------
  function automatic int clampi(int v, int lo, int hi);
    return (v < lo) ? lo : ((v > hi) ? hi : v);
  endfunction

  function automatic int rnd(longint n, int sh);
    longint half = longint'(1) <<< (sh - 1);
    return int'((n + half) >>> sh);
  endfunction

  function automatic int prim_lim(bit st, bit hi);
    return st ? (hi ? 235 : 16) : (hi ? 255 : 0);
  endfunction

  function automatic int chr_lim(bit st, bit hi);
    return st ? (hi ? 112 : -112) : (hi ? 127 : -128);
  endfunction

  function automatic int dec_prim(logic [7:0] c, bit cm, bit st);
    int v = cm ? 255 - int'(c) : int'(c);
    return clampi(v, prim_lim(st, 0), prim_lim(st, 1));
  endfunction

  function automatic int dec_chr(logic [7:0] c, bit tw, bit st);
    int v = tw ? ((c >= 128) ? int'(c) - 256 : int'(c)) : int'(c) - 128;
    return clampi(v, chr_lim(st, 0), chr_lim(st, 1));
  endfunction

  function automatic logic [7:0] enc_prim(int v, bit cm, bit st);
    int c = clampi(v, prim_lim(st, 0), prim_lim(st, 1));
    return 8'(cm ? 255 - c : c);
  endfunction

  function automatic logic [7:0] enc_chr(int v, bit tw, bit st);
    int c = clampi(v, chr_lim(st, 0), chr_lim(st, 1));
    return 8'(tw ? ((c < 0) ? c + 256 : c) : c + 128);
  endfunction

  function automatic logic [23:0] model(logic [7:0] a, logic [7:0] b, logic [7:0] c,
                                        bit inv, bit st, bit tw, bit cm, bit by);
    int o0, o1, o2;
    if (!inv) begin
      int r = dec_prim(a, cm, st), g = dec_prim(b, cm, st), bl = dec_prim(c, cm, st);
      int s = 306 * r + 601 * g + 117 * bl;
      if (by) begin o0 = r; o1 = g - 128; o2 = bl - 128; end
      else begin
        o0 = rnd(longint'(s), 10);
        o1 = rnd(longint'(1024 * bl - s) * (st ? 591 : 578), 20);
        o2 = rnd(longint'(1024 * r - s) * (st ? 746 : 730), 20);
      end
      return {enc_prim(o0, 1'b0, st), enc_chr(o1, tw, st), enc_chr(o2, tw, st)};
    end else begin
      int y = dec_prim(a, 1'b0, st), cb = dec_chr(b, tw, st), cr = dec_chr(c, tw, st);
      if (by) begin o0 = y; o1 = cb + 128; o2 = cr + 128; end
      else begin
        o0 = rnd(longint'(1024 * y + (st ? 1403 : 1436) * cr), 10);
        o1 = rnd(longint'(1024 * y - (st ? 715 : 731) * cr - (st ? 344 : 352) * cb), 10);
        o2 = rnd(longint'(1024 * y + (st ? 1772 : 1815) * cb), 10);
      end
      return {enc_prim(o0, cm, st), enc_prim(o1, cm, st), enc_prim(o2, cm, st)};
    end
  endfunction

  // ---------------- helpers ----------------
  task automatic check(string req, logic [23:0] act, logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(logic [7:0] a, logic [7:0] b, logic [7:0] c, bit inv, bit st, bit tw, bit cm, bit by);
    src0 = a; src1 = b; src2 = c;
    inv_dir = inv; studio_range = st; chroma_twos = tw; cmy_side = cm; bypass_mtx = by;
  endtask

  task automatic run_one(logic [7:0] a, logic [7:0] b, logic [7:0] c, bit inv, bit st, bit tw,
                         bit cm, bit by, output logic [23:0] got);
    @(negedge clk);
    drive(a, b, c, inv, st, tw, cm, by);
    repeat (LAT) @(posedge clk);
    @(negedge clk);
    got = {dst0, dst1, dst2};
  endtask

  task automatic vec(string req, logic [7:0] a, logic [7:0] b, logic [7:0] c,
                     bit inv, bit st, bit tw, bit cm, bit by);
    logic [23:0] got;
    run_one(a, b, c, inv, st, tw, cm, by, got);
    check(req, got, model(a, b, c, inv, st, tw, cm, by));
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset;
    @(negedge clk);
    drive(8'h5A, 8'hC3, 8'h11, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset outputs", {dst0, dst1, dst2}, 24'h000000);
    rst_n = 1'b1;
  endtask

  task automatic t_forward_full;
    logic [23:0] got;
    run_one(8'hFF, 8'hFF, 8'hFF, 0, 0, 0, 0, 0, got);
    check("R2 R3 white", got, 24'hFF8080);
    vec("R2 R3 red", 8'hFF, 8'h00, 8'h00, 0, 0, 0, 0, 0);
    vec("R2 R3 blue", 8'h00, 8'h00, 8'hFF, 0, 0, 0, 0, 0);
    vec("R2 R3 mixed", 8'h37, 8'hA4, 8'h6E, 0, 0, 0, 0, 0);
  endtask

  task automatic t_forward_studio;
    logic [23:0] got;
    run_one(8'h00, 8'h00, 8'h00, 0, 1, 0, 0, 0, got);
    check("R5 studio input clamp", got, 24'h108080);
    vec("R3 R5 studio saturated", 8'hFF, 8'h00, 8'h80, 0, 1, 0, 0, 0);
  endtask

  task automatic t_inverse;
    logic [23:0] got;
    vec("R4 inverse full", 8'h80, 8'hB2, 8'h62, 1, 0, 0, 0, 0);
    run_one(8'hFF, 8'h80, 8'hFF, 1, 0, 0, 0, 0, got);
    check("R5 inverse red saturates", {16'h0, got[23:16]}, 24'h0000FF);
    check("R4 inverse saturated", got, model(8'hFF, 8'h80, 8'hFF, 1, 0, 0, 0, 0));
    vec("R4 R5 inverse studio", 8'h00, 8'hF8, 8'h08, 1, 1, 0, 0, 0);
  endtask

  task automatic t_sign;
    vec("R6 forward twos", 8'hFF, 8'h00, 8'h00, 0, 0, 1, 0, 0);
    vec("R6 inverse twos", 8'h70, 8'h20, 8'hE0, 1, 0, 1, 0, 0);
  endtask

  task automatic t_cmy;
    logic [23:0] got;
    run_one(8'h00, 8'h00, 8'h00, 0, 0, 0, 1, 0, got);
    check("R7 cmy forward", got, 24'hFF8080);
    run_one(8'hFF, 8'h80, 8'h80, 1, 0, 0, 1, 0, got);
    check("R7 cmy inverse", got, 24'h000000);
  endtask

  task automatic t_bypass;
    logic [23:0] got;
    run_one(8'h12, 8'h9A, 8'h3C, 0, 0, 0, 0, 1, got);
    check("R8 bypass forward", got, 24'h129A3C);
    run_one(8'h50, 8'hF0, 8'h05, 1, 1, 0, 0, 1, got);
    check("R8 bypass inverse studio", got, 24'h50EB10);
    run_one(8'h40, 8'h10, 8'hC8, 0, 0, 1, 0, 1, got);
    check("R8 bypass twos", got, 24'h409048);
  endtask

  task automatic t_stream;
    localparam int N = 14;
    logic [7:0] sa [N], sb [N], sc [N];
    bit si [N], ss [N], st [N], sm [N], sy [N];
    for (int k = 0; k < N; k++) begin
      sa[k] = 8'(k * 37 + 5); sb[k] = 8'(k * 91 + 200); sc[k] = 8'(k * 53 + 77);
      si[k] = k[0]; ss[k] = k[1]; st[k] = (k % 3) == 1; sm[k] = k[2]; sy[k] = (k == 5) || (k == 10);
    end
    for (int k = 0; k < N + LAT; k++) begin
      @(negedge clk);
      if (k >= LAT)
        check("R9 stream latency", {dst0, dst1, dst2},
              model(sa[k-LAT], sb[k-LAT], sc[k-LAT], si[k-LAT], ss[k-LAT], st[k-LAT], sm[k-LAT], sy[k-LAT]));
      if (k < N) drive(sa[k], sb[k], sc[k], si[k], ss[k], st[k], sm[k], sy[k]);
    end
  endtask

  initial begin
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_forward_full();
    t_forward_studio();
    t_inverse();
    t_sign();
    t_cmy();
    t_bypass();
    t_stream();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R9 watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule